// File: doc/BRIEF.md
# Programming Command Test Data Register

This block is a test data register that sits behind a TAP controller. It carries programming commands from the scan port into a memory-programming engine and returns the result of each command on the same chain. The TAP controller supplies the state decodes and the current instruction. The block only acts while the program-command instruction is loaded.

A capture loads the engine's result word into a 15-bit shift chain. During shift, each TCK moves that result out on TDO and moves the next command in from TDI. An update copies the chain into a latch that drives the engine's command inputs, and raises a one-cycle valid strobe. Each TCK spent in Run-Test/Idle then produces one execute pulse. Commands that complete on update alone can skip the idle cycles.

Top module: `jtag_pcmd_dr`

## Requirements
- R1: While `rst_ni` is low, the shift chain and the command latch are cleared at once, without waiting for a clock. As a result `tdo_o`, `cmd_o`, `cmd_valid_o` and `exec_o` are all 0.
- R2: A TCK rising edge with `capture_dr_i` high and the block selected loads `result_i` into the shift chain. `tdo_o` then shows `result_i[0]`.
- R3: The shift chain is 15 bits wide and shifts LSB first. On each selected TCK edge with `shift_dr_i` high, `tdi_i` enters bit 14 and every bit moves one place toward bit 0. `tdo_o` always equals bit 0. After 15 shifts the captured result has been fully shifted out and the new command fully shifted in.
- R4: A selected TCK edge with `update_dr_i` high copies the shift chain to `cmd_o`. `cmd_valid_o` is high for exactly the one TCK cycle that follows that edge.
- R5: `cmd_o` changes only on an update edge. It holds its value through capture, shift and idle.
- R6: Each selected TCK edge with `run_idle_i` high makes `exec_o` high for the following cycle. An edge without `run_idle_i` leaves `exec_o` low for the following cycle. With zero idle cycles, no execute pulse is produced.
- R7: The block is selected only when the 4-bit `ir_i` equals 4'h5. With any other value, the capture, shift, update and idle decodes have no effect: `tdo_o`, `cmd_o` and `cmd_valid_o` keep their values, and `exec_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test-logic reset |
| ir_i | input | 4 | Current instruction; 4'h5 selects this register |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| run_idle_i | input | 1 | TAP is in Run-Test/Idle |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (chain bit 0) |
| result_i | input | 15 | Result word of the previous command, from the engine |
| cmd_o | output | 15 | Latched command word to the engine |
| cmd_valid_o | output | 1 | One-cycle strobe after an update |
| exec_o | output | 1 | Execute pulse, one per idle TCK |

## Verification
All results are registered on the rising TCK edge in which the state decode is high. Capture, each shift, update and each idle cycle therefore show their effect one edge after they are driven: `tdo_o` right after the capture or shift edge, `cmd_o` and `cmd_valid_o` after the update edge, and `exec_o` after each idle edge. The bench drives each step on the falling edge and samples 1 ns after the next rising edge. Each TDO bit is read before the edge that shifts it away. The reset checks sample in the middle of a cycle, with no clock edge in between, which shows that the reset clears the state at once.

// File: rtl/pcmd_pkg.sv
package pcmd_pkg;
  localparam int CMD_W = 15;
  localparam int IR_W  = 4;
  localparam logic [IR_W-1:0] PCMD_OPCODE = 4'h5;
  typedef logic [CMD_W-1:0] cmd_t;
endpackage

// File: rtl/pcmd_shift.sv
module pcmd_shift #(
  parameter int W = 15
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         tdi_i,
  input  logic [W-1:0] par_i,
  output logic         tdo_o,
  output logic [W-1:0] par_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (capture_i) sr_q <= par_i;
    else if (shift_i)   sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  assign tdo_o = sr_q[0];
  assign par_o = sr_q;

  // R2
  capture_load_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> sr_q == $past(par_i));
  // R3
  shift_lsb_first_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> (sr_q[W-1] == $past(tdi_i)) && (sr_q[W-2:0] == $past(sr_q[W-1:1])));
  // R3
  chain_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!shift_i && !capture_i) |=> $stable(sr_q));
endmodule

// File: rtl/pcmd_update.sv
module pcmd_update #(
  parameter int W = 15
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         update_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cmd_o,
  output logic         valid_o
);
  logic [W-1:0] cmd_q;
  logic         valid_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= update_i;
      if (update_i) cmd_q <= d_i;
    end
  end

  assign cmd_o   = cmd_q;
  assign valid_o = valid_q;

  // R4
  update_apply_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    update_i |=> (cmd_q == $past(d_i)) && valid_q);
  // R5
  cmd_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(cmd_q) && !valid_q);
endmodule

// File: rtl/pcmd_exec.sv
module pcmd_exec (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic exec_o
);
  logic exec_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) exec_q <= 1'b0;
    else         exec_q <= run_i;
  end

  assign exec_o = exec_q;

  // R6
  exec_pulse_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    run_i |=> exec_q);
  // R6
  exec_quiet_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !run_i |=> !exec_q);
endmodule

// File: rtl/jtag_pcmd_dr.sv
module jtag_pcmd_dr #(
  parameter int CMD_W = pcmd_pkg::CMD_W,
  parameter int IR_W  = pcmd_pkg::IR_W,
  parameter logic [IR_W-1:0] OPCODE = pcmd_pkg::PCMD_OPCODE
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic [IR_W-1:0]  ir_i,
  input  logic             capture_dr_i,
  input  logic             shift_dr_i,
  input  logic             update_dr_i,
  input  logic             run_idle_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  input  logic [CMD_W-1:0] result_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_valid_o,
  output logic             exec_o
);
  logic             sel;
  logic [CMD_W-1:0] chain;

  assign sel = (ir_i == OPCODE);

  pcmd_shift #(.W(CMD_W)) u_shift (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .capture_i(sel & capture_dr_i),
    .shift_i  (sel & shift_dr_i),
    .tdi_i    (tdi_i),
    .par_i    (result_i),
    .tdo_o    (tdo_o),
    .par_o    (chain)
  );

  pcmd_update #(.W(CMD_W)) u_update (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .update_i(sel & update_dr_i),
    .d_i     (chain),
    .cmd_o   (cmd_o),
    .valid_o (cmd_valid_o)
  );

  pcmd_exec u_exec (
    .tck_i (tck_i),
    .rst_ni(rst_ni),
    .run_i (sel & run_idle_i),
    .exec_o(exec_o)
  );

  // R7
  unsel_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel |=> $stable(cmd_o) && $stable(tdo_o) && !exec_o && !cmd_valid_o);
  // R1
  reset_clear_chk: assert property (@(posedge tck_i)
    !rst_ni |-> (cmd_o == '0) && !tdo_o && !exec_o && !cmd_valid_o);
endmodule

// File: tb/jtag_pcmd_dr_test.sv
module jtag_pcmd_dr_test;
  localparam int W = 15;
  localparam logic [W-1:0] ECHO_MASK = 15'h5555;
  localparam int NV = 5;
  // {command, expected captured result, idle cycles}
  localparam logic [W-1:0] VEC_CMD [NV] = '{15'h2301, 15'h7FFF, 15'h0000, 15'h4A5A, 15'h1C3E};
  localparam logic [W-1:0] VEC_RES [NV] = '{15'h5555, 15'h7654, 15'h2AAA, 15'h5555, 15'h1F0F};
  localparam int           VEC_IDL [NV] = '{1, 0, 3, 2, 1};

  logic tck = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] ir = 4'h5;
  logic cap = 0, sh = 0, upd = 0, idl = 0, tdi = 0;
  logic tdo, cmd_valid, exec_p;
  logic [W-1:0] result, cmd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  assign result = cmd ^ ECHO_MASK;

  jtag_pcmd_dr uut (
    .tck_i(tck), .rst_ni(rst_ni), .ir_i(ir),
    .capture_dr_i(cap), .shift_dr_i(sh), .update_dr_i(upd), .run_idle_i(idl),
    .tdi_i(tdi), .tdo_o(tdo), .result_i(result), .cmd_o(cmd),
    .cmd_valid_o(cmd_valid), .exec_o(exec_p)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic s, input logic u, input logic r, input logic d);
    @(negedge tck);
    cap = c; sh = s; upd = u; idl = r; tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      report();
    end
  end

  initial begin
    logic [W-1:0] got;
    // R1: reset state before any clock edge
    #1;
    chk(cmd == '0 && !tdo && !cmd_valid && !exec_p, "R1", cmd, '0);
    #10;
    @(negedge tck);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step(1, 0, 0, 0, 0);
      // R2: first result bit visible right after capture
      chk(tdo == VEC_RES[k][0], "R2", {14'd0, tdo}, {14'd0, VEC_RES[k][0]});
      got = '0;
      for (int i = 0; i < W; i++) begin
        got[i] = tdo;
        step(0, 1, 0, 0, VEC_CMD[k][i]);
        // R5: command latch untouched during shift
        if (i == W - 1) chk(cmd == (k == 0 ? '0 : VEC_CMD[k-1]), "R5", cmd, (k == 0 ? '0 : VEC_CMD[k-1]));
      end
      // R2 R3: whole previous result shifted out LSB first
      chk(got == VEC_RES[k], "R3", got, VEC_RES[k]);
      step(0, 0, 1, 0, 0);
      // R4
      chk(cmd == VEC_CMD[k] && cmd_valid, "R4", cmd, VEC_CMD[k]);
      for (int j = 0; j < VEC_IDL[k]; j++) begin
        step(0, 0, 0, 1, 0);
        // R6 R4: one exec per idle cycle, valid strobe already gone
        chk(exec_p && !cmd_valid, "R6", {13'd0, exec_p, cmd_valid}, 15'd2);
      end
      step(0, 0, 0, 0, 0);
      // R6: no exec without idle
      chk(!exec_p && !cmd_valid, "R6", {13'd0, exec_p, cmd_valid}, '0);
      chk(cmd == VEC_CMD[k], "R5", cmd, VEC_CMD[k]);
    end

    // R7: other instruction; chain holds 1C3E so tdo=0
    ir = 4'h4;
    step(1, 0, 0, 0, 0);
    chk(tdo == 1'b0, "R7", {14'd0, tdo}, '0);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 1);
    chk(tdo == 1'b0, "R7", {14'd0, tdo}, '0);
    step(0, 0, 1, 0, 0);
    chk(cmd == 15'h1C3E && !cmd_valid, "R7", cmd, 15'h1C3E);
    step(0, 0, 0, 1, 0);
    chk(!exec_p, "R7", {14'd0, exec_p}, '0);
    ir = 4'h5;

    // R3: bits walk toward tdo one per shift
    step(0, 1, 0, 0, 1);
    chk(tdo == 1'b1, "R3", {14'd0, tdo}, 15'd1);

    // R1: async reset mid-operation with exec active
    step(0, 0, 0, 1, 0);
    @(negedge tck);
    idl = 0;
    rst_ni = 1'b0;
    #0.5;
    chk(cmd == '0 && !tdo && !exec_p && !cmd_valid, "R1", cmd, '0);
    @(negedge tck);
    rst_ni = 1'b1;
    step(1, 0, 0, 0, 0);
    // R2: result after reset is echo of zero command
    chk(tdo == ECHO_MASK[0], "R2", {14'd0, tdo}, {14'd0, ECHO_MASK[0]});

    done = 1;
    report();
  end
endmodule